// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block is the command front end of a byte-wide flash memory model. It watches a stream of bus write cycles, each offered as a one-cycle write strobe with an address and a data byte, and recognises the unlock sequences that start an operation. Three kinds of sequence are accepted: byte program, erase (sector, block or whole chip), and entry to or exit from product identification mode.

An operation that is accepted produces a one-cycle start pulse together with the latched target address and data. The decoder then stays busy until the array engine reports completion. Any write that does not fit the sequence in progress aborts it and returns the decoder to standby. Chip erase is honoured only when the parallel, multiplexed-address programming mode is selected.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, or after either of the two active-low reset inputs goes low in any state, the decoder is in standby: busy is 0, idMode is 0, idByte is 00h and no start pulse fires. A partly entered sequence does not survive the reset.
- R2: A byte program is started by four writes: AAh at unlock address A (5555h), 55h at unlock address B (2AAAh), A0h at address A, and then any address with any data. Only the low 15 address bits are compared against the unlock addresses.
- R3: An erase setup is AAh@A, 55h@B, 80h@A, AAh@A, 55h@B. A sixth write of 30h at any address starts a sector erase, and tgtAddr takes that address.
- R4: The same five-write setup followed by 50h at any address starts a block erase, and tgtAddr takes that address.
- R5: The erase setup followed by 10h at address A starts a chip erase only while muxMode is 1. With muxMode at 0 the sequence is rejected, no pulse fires and the decoder returns to standby.
- R6: A write with a wrong address or data at any step aborts the sequence without a pulse. The next complete sequence is then accepted normally.
- R7: AAh@A, 55h@B, 90h@A sets idMode. While idMode is set, idByte is 99h with rdSel=0 and DEV_ID (default 86h) with rdSel=1. It is 00h while idMode is clear. AAh@A, 55h@B, F0h@A clears idMode.
- R8: A start pulse sets busy. While busy, writes are ignored, including complete sequences, and busy stays set until opDone is high at a clock edge.
- R9: At most one of progStart, sectErase, blockErase and chipErase is high in any cycle, and each is high for exactly one cycle.
- R10: The start pulse, tgtAddr and tgtData (the data of the final write, for program) appear in the cycle after the clock edge that samples the final write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstA_n | input | 1 | Active-low reset, first source |
| rstB_n | input | 1 | Active-low reset, second source |
| muxMode | input | 1 | Parallel programming mode selected; enables chip erase |
| wrEn | input | 1 | One-cycle write strobe |
| wrAddr | input | ADDR_W (19) | Write address |
| wrData | input | 8 | Write data |
| opDone | input | 1 | Program/erase finished |
| rdSel | input | 1 | ID read offset (0 manufacturer, 1 device) |
| progStart | output | 1 | Byte program start pulse |
| sectErase | output | 1 | Sector erase start pulse |
| blockErase | output | 1 | Block erase start pulse |
| chipErase | output | 1 | Chip erase start pulse |
| tgtAddr | output | ADDR_W (19) | Latched target address |
| tgtData | output | 8 | Latched program data |
| busy | output | 1 | Operation in progress |
| idMode | output | 1 | Product identification mode active |
| idByte | output | 8 | Identification byte for rdSel |

## Verification
The hardest behaviour to reach is a complete, valid sequence arriving while an operation is still busy. That needs a prior operation that has been started and deliberately left without opDone. The bench starts a program, replays a full program sequence during busy, and expects silence on all start pulses. Aborts are forced at the second, third and fifth steps, and a reset is asserted both in the middle of a sequence and during busy. Each abort is followed by a valid sequence to show that the decoder recovered.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] CMD_UNLK1  = 8'hAA;
  localparam logic [7:0] CMD_UNLK2  = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ESETUP = 8'h80;
  localparam logic [7:0] CMD_IDIN   = 8'h90;
  localparam logic [7:0] CMD_IDOUT  = 8'hF0;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_BLOCK  = 8'h50;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PROG, S_ERS1, S_ERS2, S_ERS3, S_BUSY
  } seqState_t;

  typedef struct packed {
    logic ldTarget;
    logic setId;
    logic clrId;
    logic goProg;
    logic goSect;
    logic goBlock;
    logic goChip;
  } ctlStrobe_t;
endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int CMP_W = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CMP_W-1:0] wrAddrLo,
  input  logic [7:0]       wrData,
  input  logic             muxMode,
  input  logic             opDone,
  output ctlStrobe_t       ctl,
  output logic             busy
);
  localparam logic [CMP_W-1:0] ADR_A = CMP_W'(16'h5555);
  localparam logic [CMP_W-1:0] ADR_B = CMP_W'(16'h2AAA);

  seqState_t st, nxt;
  logic hitA, hitB;

  assign hitA = (wrAddrLo == ADR_A);
  assign hitB = (wrAddrLo == ADR_B);

  always_comb begin
    nxt = st;
    ctl = '0;
    unique case (st)
      S_IDLE: if (wrEn && hitA && wrData == CMD_UNLK1) nxt = S_UNL1;
      S_UNL1: if (wrEn) nxt = (hitB && wrData == CMD_UNLK2) ? S_UNL2 : S_IDLE;
      S_UNL2: if (wrEn) begin
        nxt = S_IDLE;
        if (hitA) begin
          case (wrData)
            CMD_PROG:   nxt = S_PROG;
            CMD_ESETUP: nxt = S_ERS1;
            CMD_IDIN:   ctl.setId = 1'b1;
            CMD_IDOUT:  ctl.clrId = 1'b1;
            default:    nxt = S_IDLE;
          endcase
        end
      end
      S_PROG: if (wrEn) begin
        ctl.ldTarget = 1'b1;
        ctl.goProg   = 1'b1;
        nxt          = S_BUSY;
      end
      S_ERS1: if (wrEn) nxt = (hitA && wrData == CMD_UNLK1) ? S_ERS2 : S_IDLE;
      S_ERS2: if (wrEn) nxt = (hitB && wrData == CMD_UNLK2) ? S_ERS3 : S_IDLE;
      S_ERS3: if (wrEn) begin
        nxt = S_IDLE;
        if (wrData == CMD_CHIP && hitA && muxMode) begin
          ctl.goChip = 1'b1;
          nxt        = S_BUSY;
        end else if (wrData == CMD_SECT) begin
          ctl.ldTarget = 1'b1;
          ctl.goSect   = 1'b1;
          nxt          = S_BUSY;
        end else if (wrData == CMD_BLOCK) begin
          ctl.ldTarget = 1'b1;
          ctl.goBlock  = 1'b1;
          nxt          = S_BUSY;
        end
      end
      S_BUSY: if (opDone) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  assign busy = (st == S_BUSY);
endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W = 19,
  parameter logic [7:0] MFG_ID = 8'h99,
  parameter logic [7:0] DEV_ID = 8'h86
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              rdSel,
  output logic              progStart,
  output logic              sectErase,
  output logic              blockErase,
  output logic              chipErase,
  output logic [ADDR_W-1:0] tgtAddr,
  output logic [7:0]        tgtData,
  output logic              idMode,
  output logic [7:0]        idByte
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progStart  <= 1'b0;
      sectErase  <= 1'b0;
      blockErase <= 1'b0;
      chipErase  <= 1'b0;
      tgtAddr    <= '0;
      tgtData    <= '0;
      idMode     <= 1'b0;
    end else begin
      progStart  <= ctl.goProg;
      sectErase  <= ctl.goSect;
      blockErase <= ctl.goBlock;
      chipErase  <= ctl.goChip;
      if (ctl.ldTarget) begin
        tgtAddr <= wrAddr;
        tgtData <= wrData;
      end
      if (ctl.setId)      idMode <= 1'b1;
      else if (ctl.clrId) idMode <= 1'b0;
    end
  end

  assign idByte = !idMode ? 8'h00 : (rdSel ? DEV_ID : MFG_ID);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W = 19,
  parameter int         CMP_W  = 15,
  parameter logic [7:0] DEV_ID = 8'h86
) (
  input  logic              clk,
  input  logic              rstA_n,
  input  logic              rstB_n,
  input  logic              muxMode,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              opDone,
  input  logic              rdSel,
  output logic              progStart,
  output logic              sectErase,
  output logic              blockErase,
  output logic              chipErase,
  output logic [ADDR_W-1:0] tgtAddr,
  output logic [7:0]        tgtData,
  output logic              busy,
  output logic              idMode,
  output logic [7:0]        idByte
);
  logic       rstN;
  ctlStrobe_t ctl;

  assign rstN = rstA_n & rstB_n;

  flash_cmd_ctrl #(.CMP_W(CMP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddrLo(wrAddr[CMP_W-1:0]),
    .wrData(wrData), .muxMode(muxMode), .opDone(opDone), .ctl(ctl), .busy(busy)
  );

  flash_cmd_dp #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrAddr(wrAddr), .wrData(wrData),
    .rdSel(rdSel), .progStart(progStart), .sectErase(sectErase),
    .blockErase(blockErase), .chipErase(chipErase), .tgtAddr(tgtAddr),
    .tgtData(tgtData), .idMode(idMode), .idByte(idByte)
  );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
  input logic clk,
  input logic rstA_n,
  input logic rstB_n,
  input logic muxMode,
  input logic opDone,
  input logic progStart,
  input logic sectErase,
  input logic blockErase,
  input logic chipErase,
  input logic busy
);
  logic rstN, anyStart;
  assign rstN     = rstA_n & rstB_n;
  assign anyStart = progStart | sectErase | blockErase | chipErase;

  a_r9_one_start: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progStart, sectErase, blockErase, chipErase}));

  a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    anyStart |=> !anyStart);

  a_r8_busy_with_start: assert property (@(posedge clk) disable iff (!rstN)
    anyStart |-> busy);

  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !opDone) |=> busy);

  a_r8_quiet_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !opDone) |=> !anyStart);

  a_r5_chip_needs_mux: assert property (@(posedge clk) disable iff (!rstN)
    chipErase |-> $past(muxMode));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk(clk), .rstA_n(rstA_n), .rstB_n(rstB_n), .muxMode(muxMode),
  .opDone(opDone), .progStart(progStart), .sectErase(sectErase),
  .blockErase(blockErase), .chipErase(chipErase), .busy(busy)
);

// File: tb/sim_flash_cmd_seq.sv
`timescale 1ns/1ps
module sim_flash_cmd_seq;
  localparam int AW = 19;

  typedef struct {
    int          kind;
    logic [AW-1:0] addr;
    logic [7:0]  data;
    string       req;
  } expItem_t;

  logic clk = 1'b0;
  logic rstA_n = 1'b0, rstB_n = 1'b0, muxMode = 1'b0, wrEn = 1'b0, opDone = 1'b0, rdSel = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic progStart, sectErase, blockErase, chipErase, busy, idMode;
  logic [AW-1:0] tgtAddr;
  logic [7:0] tgtData, idByte;

  int checks = 0, errors = 0;
  bit finished = 0;
  expItem_t expQ[$];

  always #2 clk = ~clk;

  flash_cmd_seq u0 (
    .clk(clk), .rstA_n(rstA_n), .rstB_n(rstB_n), .muxMode(muxMode), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .opDone(opDone), .rdSel(rdSel),
    .progStart(progStart), .sectErase(sectErase), .blockErase(blockErase),
    .chipErase(chipErase), .tgtAddr(tgtAddr), .tgtData(tgtData), .busy(busy),
    .idMode(idMode), .idByte(idByte)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // monitor: pops the scoreboard on every start pulse (R9, R10)
  always @(negedge clk) begin
    if (rstA_n && rstB_n && (progStart | sectErase | blockErase | chipErase)) begin
      int kind;
      kind = progStart ? 1 : sectErase ? 2 : blockErase ? 3 : 4;
      check("R9 single pulse", 32'($countones({progStart, sectErase, blockErase, chipErase})), 1);
      if (expQ.size() == 0) begin
        check("R8/R6 unexpected start", 32'(kind), 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(e.req, 32'(kind), 32'(e.kind));
        if (e.kind != 4) check(e.req, 32'(tgtAddr), 32'(e.addr));
        if (e.kind == 1) check(e.req, 32'(tgtData), 32'(e.data));
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic unlock();
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
  endtask

  task automatic expect_op(input int k, input logic [AW-1:0] a, input logic [7:0] d, input string r);
    expItem_t e;
    e.kind = k; e.addr = a; e.data = d; e.req = r;
    expQ.push_back(e);
  endtask

  task automatic drained(input string r);
    @(negedge clk);
    check(r, 32'(expQ.size()), 0);
    expQ.delete();
  endtask

  task automatic done();
    @(negedge clk); opDone = 1'b1;
    @(negedge clk); opDone = 1'b0;
  endtask

  task automatic do_prog(input logic [AW-1:0] a, input logic [7:0] d, input string r);
    unlock(); wr(19'h05555, 8'hA0);
    expect_op(1, a, d, r);
    wr(a, d);
  endtask

  task automatic erase_setup();
    unlock(); wr(19'h05555, 8'h80); unlock();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstA_n = 1'b1; rstB_n = 1'b1;
    @(negedge clk);
    check("R1 reset busy", 32'(busy), 0);
    check("R1 reset idMode", 32'(idMode), 0);
    check("R1 reset idByte", 32'(idByte), 0);

    // R2 program, R10 timing (monitor samples at negedge right after sampling edge)
    do_prog(19'h71234, 8'h3C, "R2 program");
    check("R8 busy after program", 32'(busy), 1);
    drained("R10 program pulse timing");

    // R8 full sequence while busy is ignored
    unlock(); wr(19'h05555, 8'hA0); wr(19'h00010, 8'hEE);
    erase_setup(); wr(19'h12000, 8'h30);
    drained("R8 ignored while busy");
    check("R8 still busy", 32'(busy), 1);
    done();
    check("R8 idle after done", 32'(busy), 0);

    // R2 high address bits ignored in unlock compare
    unlock(); wr(19'h45555, 8'hA0);
    expect_op(1, 19'h00042, 8'h5A, "R2 high bits ignored");
    wr(19'h00042, 8'h5A);
    drained("R2 high bits ignored"); done();

    // R3 sector erase
    erase_setup();
    expect_op(2, 19'h42000, 8'h00, "R3 sector erase");
    wr(19'h42000, 8'h30);
    drained("R3 sector erase"); done();

    // R4 block erase
    erase_setup();
    expect_op(3, 19'h50000, 8'h00, "R4 block erase");
    wr(19'h50000, 8'h50);
    drained("R4 block erase"); done();

    // R5 chip erase rejected without mux mode
    muxMode = 1'b0;
    erase_setup(); wr(19'h05555, 8'h10);
    drained("R5 chip rejected");
    check("R5 rejected not busy", 32'(busy), 0);
    muxMode = 1'b1;
    erase_setup();
    expect_op(4, '0, 8'h00, "R5 chip erase");
    wr(19'h05555, 8'h10);
    drained("R5 chip erase");
    check("R5 chip busy", 32'(busy), 1);
    done(); muxMode = 1'b0;

    // R6 aborts at several steps, each followed by recovery
    wr(19'h05555, 8'hAA); wr(19'h02AAB, 8'h55); wr(19'h05555, 8'hA0); wr(19'h00100, 8'h11);
    drained("R6 bad second address");
    check("R6 abort not busy", 32'(busy), 0);
    unlock(); wr(19'h05555, 8'h77); wr(19'h00100, 8'h11);
    drained("R6 bad command");
    unlock(); wr(19'h05555, 8'h80); wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h54); wr(19'h30000, 8'h30);
    drained("R6 bad fifth data");
    check("R6 abort erase not busy", 32'(busy), 0);
    do_prog(19'h00200, 8'h22, "R6 recovery program");
    drained("R6 recovery program"); done();

    // R7 ID mode
    unlock(); wr(19'h05555, 8'h90);
    check("R7 id entry", 32'(idMode), 1);
    rdSel = 1'b0; #1 check("R7 manufacturer id", 32'(idByte), 32'h99);
    rdSel = 1'b1; #1 check("R7 device id", 32'(idByte), 32'h86);
    unlock(); wr(19'h05555, 8'hF0);
    check("R7 id exit", 32'(idMode), 0);
    check("R7 idByte cleared", 32'(idByte), 0);
    rdSel = 1'b0;

    // R1 reset during busy and mid-sequence
    do_prog(19'h00300, 8'h33, "R1 pre-reset program");
    drained("R1 pre-reset program");
    @(negedge clk); rstB_n = 1'b0; @(negedge clk); rstB_n = 1'b1;
    check("R1 reset aborts busy", 32'(busy), 0);
    unlock(); wr(19'h05555, 8'h90);
    unlock();
    @(negedge clk); rstA_n = 1'b0; @(negedge clk); rstA_n = 1'b1;
    check("R1 reset clears idMode", 32'(idMode), 0);
    wr(19'h05555, 8'hA0); wr(19'h00400, 8'h44);
    drained("R1 sequence lost on reset");
    check("R1 not busy after reset", 32'(busy), 0);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule